// File: doc/BRIEF.md
# Banked RGB Palette Lookup

This block turns a pixel value into red, green and blue panel intensities. It holds three palettes of sixteen 4-bit entries, one per color channel. A host loads entries one at a time. It names a channel and an entry address, and it can read back the entry it is currently addressing. A six-bit bank control gives each channel a two-bit bank. For narrow pixels (1 or 2 bits), the bank picks which quarter of that channel's palette the pixel reaches.

In color mode all three palettes drive the outputs, so each pixel becomes one of 4096 colors. In gray mode only the green palette is looked up: the shade appears on the green output and the red and blue outputs stay at zero. There is one registered lookup stage, so the outputs follow the pixel input one clock later.

Top module: `pal_lut_top`

## Requirements
- R1: While rst_ni is low, red_o, green_o and blue_o are 0 and every palette entry k of every channel holds the value k.
- R2: When host_we_i is high at a rising edge, the entry at host_addr_i of the channel named by host_chan_i (00 red, 01 green, 10 blue) takes host_wdata_i. The new value is visible from the next clock on. In the cycle of the write, a read of that entry returns the old value.
- R3: host_rdata_o shows, without a clock, the entry at host_addr_i of the channel named by host_chan_i.
- R4: With host_chan_i = 11, a write changes no palette entry and host_rdata_o reads 0.
- R5: bank_ctrl_i bits [1:0] are the red bank, [3:2] the green bank and [5:4] the blue bank. At depth_i = 00 (1 bit per pixel) a channel's entry index is {bank, 0, pixel[0]}.
- R6: At depth_i = 01 (2 bits per pixel) a channel's entry index is {bank, pixel[1:0]}.
- R7: At depth_i = 10 (4 bits per pixel) every channel uses pixel[3:0] as its index, and the bank bits have no effect.
- R8: At depth_i = 11 in color mode, red uses {red bank[1], pixel[7:5]}, green uses {green bank[1], pixel[4:2]} and blue uses {blue bank, pixel[1:0]}.
- R9: When color_mode_i is 0 (gray), red_o and blue_o are 0 and green_o is the green palette entry. At depth_i = 11 the green index in gray mode is pixel[7:4].
- R10: The outputs change one clock after pixel_i, depth_i, color_mode_i or bank_ctrl_i change, and they hold until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host palette write strobe |
| host_chan_i | input | 2 | Host channel select (00 R, 01 G, 10 B, 11 none) |
| host_addr_i | input | 4 | Host palette entry address |
| host_wdata_i | input | 4 | Host write data |
| host_rdata_o | output | 4 | Addressed entry readback |
| bank_ctrl_i | input | 6 | Per-channel bank fields |
| depth_i | input | 2 | Bits per pixel: 00=1, 01=2, 10=4, 11=8 |
| color_mode_i | input | 1 | 1 color, 0 gray |
| pixel_i | input | 8 | Pixel value |
| red_o | output | 4 | Red intensity |
| green_o | output | 4 | Green intensity or gray shade |
| blue_o | output | 4 | Blue intensity |

## Verification
Some properties are checked on every cycle by assertions. A palette changes only on a write. A write lands at the entry it names. The unused channel code reads zero. Gray mode blanks red and blue. The outputs hold when the inputs and palettes did not change.

Other behaviour shows only in the bench scenarios:
- whether each depth and mode builds the right index from the bank bits and pixel fields,
- the reset ramp contents,
- the old-value readback in the cycle of a write.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int unsigned DATA_W  = 4;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned N_CHAN  = 3;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_8 = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_NONE  = 2'd3
  } chan_e;

  function automatic logic [IDX_W-1:0] calc_index(
    input depth_e            depth,
    input logic              color,
    input int unsigned       chan,
    input logic [BANK_W-1:0] bank,
    input logic [PIX_W-1:0]  pix
  );
    logic [IDX_W-1:0] idx;
    unique case (depth)
      DEPTH_1: idx = {bank, 1'b0, pix[0]};
      DEPTH_2: idx = {bank, pix[1:0]};
      DEPTH_4: idx = pix[3:0];
      default: begin
        if (!color)         idx = pix[7:4];
        else if (chan == 0) idx = {bank[1], pix[7:5]};
        else if (chan == 1) idx = {bank[1], pix[4:2]};
        else                idx = {bank, pix[1:0]};
      end
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/pal_index_gen.sv
module pal_index_gen
  import pal_lut_pkg::*;
(
  input  depth_e                          depth_i,
  input  logic                            color_mode_i,
  input  logic [N_CHAN*BANK_W-1:0]        bank_ctrl_i,
  input  logic [PIX_W-1:0]                pixel_i,
  output logic [N_CHAN-1:0][IDX_W-1:0]    idx_o
);
  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    always_comb
      idx_o[c] = calc_index(depth_i, color_mode_i, c,
                            bank_ctrl_i[c*BANK_W +: BANK_W], pixel_i);
  end
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  host_raddr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [IDX_W-1:0]  pix_raddr_i,
  output logic [DATA_W-1:0] pix_rdata_o
);
  logic [ENTRIES-1:0][DATA_W-1:0] mem_q;

  // reset ramp: entry k holds k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ENTRIES; k++) mem_q[k] <= DATA_W'(k);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_raddr_i];
  assign pix_rdata_o  = mem_q[pix_raddr_i];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
  import pal_lut_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_we_i,
  input  logic [1:0]  host_chan_i,
  input  logic [3:0]  host_addr_i,
  input  logic [3:0]  host_wdata_i,
  output logic [3:0]  host_rdata_o,
  input  logic [5:0]  bank_ctrl_i,
  input  logic [1:0]  depth_i,
  input  logic        color_mode_i,
  input  logic [7:0]  pixel_i,
  output logic [3:0]  red_o,
  output logic [3:0]  green_o,
  output logic [3:0]  blue_o
);
  logic [N_CHAN-1:0][IDX_W-1:0]  idx;
  logic [N_CHAN-1:0][DATA_W-1:0] lut;
  logic [N_CHAN-1:0][DATA_W-1:0] host_rd;
  logic [DATA_W-1:0] red_q, green_q, blue_q;

  pal_index_gen u_idx (
    .depth_i      (depth_e'(depth_i)),
    .color_mode_i (color_mode_i),
    .bank_ctrl_i  (bank_ctrl_i),
    .pixel_i      (pixel_i),
    .idx_o        (idx)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_pal
    logic we_c;
    assign we_c = host_we_i && (host_chan_i == 2'(c));
    pal_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (we_c),
      .waddr_i      (host_addr_i),
      .wdata_i      (host_wdata_i),
      .host_raddr_i (host_addr_i),
      .host_rdata_o (host_rd[c]),
      .pix_raddr_i  (idx[c]),
      .pix_rdata_o  (lut[c])
    );
  end

  always_comb begin
    unique case (chan_e'(host_chan_i))
      CH_RED:   host_rdata_o = host_rd[0];
      CH_GREEN: host_rdata_o = host_rd[1];
      CH_BLUE:  host_rdata_o = host_rd[2];
      default:  host_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_q   <= '0;
      green_q <= '0;
      blue_q  <= '0;
    end else begin
      red_q   <= color_mode_i ? lut[0] : '0;
      green_q <= lut[1];
      blue_q  <= color_mode_i ? lut[2] : '0;
    end
  end

  assign red_o   = red_q;
  assign green_o = green_q;
  assign blue_o  = blue_q;

  // one cycle of history before the hold check may compare outputs
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  p_dead_chan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_chan_i == 2'd3 |-> host_rdata_o == '0);
  p_gray_rb_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !color_mode_i |=> (red_o == '0 && blue_o == '0));
  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(!host_we_i) && $stable(pixel_i) && $stable(depth_i)
     && $stable(color_mode_i) && $stable(bank_ctrl_i))
    |=> ($stable(red_o) && $stable(green_o) && $stable(blue_o)));
endmodule

// File: tb/pal_lut_top_tb_top.sv
`timescale 1ns/1ps
module pal_lut_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] chan = 2'd0;
  logic [3:0] addr = 4'd0;
  logic [3:0] wdata = 4'd0;
  logic [3:0] rdata;
  logic [5:0] bank = 6'd0;
  logic [1:0] depth = 2'd0;
  logic       color = 1'b0;
  logic [7:0] pixel = 8'd0;
  logic [3:0] r_o, g_o, b_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] pal [3][16];

  always #10 clk = ~clk;

  pal_lut_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_chan_i(chan),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .bank_ctrl_i(bank), .depth_i(depth), .color_mode_i(color),
    .pixel_i(pixel), .red_o(r_o), .green_o(g_o), .blue_o(b_o)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // index model written from the requirement text
  function automatic logic [3:0] model_idx(input logic [1:0] d, input logic col,
                                           input int c, input logic [5:0] bk,
                                           input logic [7:0] px);
    logic [1:0] b;
    b = bk[2*c +: 2];
    if (d == 2'd0) return {b, 1'b0, px[0]};
    if (d == 2'd1) return {b, px[1:0]};
    if (d == 2'd2) return px[3:0];
    if (!col) return px[7:4];
    if (c == 0) return {b[1], px[7:5]};
    if (c == 1) return {b[1], px[4:2]};
    return {b, px[1:0]};
  endfunction

  function automatic logic [11:0] model_out(input logic [1:0] d, input logic col,
                                            input logic [5:0] bk, input logic [7:0] px);
    logic [3:0] rr, gg, bb;
    rr = col ? pal[0][model_idx(d, col, 0, bk, px)] : 4'd0;
    gg = pal[1][model_idx(d, col, 1, bk, px)];
    bb = col ? pal[2][model_idx(d, col, 2, bk, px)] : 4'd0;
    return {rr, gg, bb};
  endfunction

  task automatic host_write(input logic [1:0] c, input logic [3:0] a, input logic [3:0] v);
    we = 1'b1; chan = c; addr = a; wdata = v;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    if (c != 2'd3) pal[c][a] = v;
  endtask

  // depth, color, bank, pixel
  typedef struct packed { logic [1:0] d; logic col; logic [5:0] bk; logic [7:0] px; } vec_t;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 6'b10_01_11, 8'h01},  // R5
    '{2'd0, 1'b1, 6'b00_11_01, 8'hFE},  // R5
    '{2'd0, 1'b0, 6'b00_10_00, 8'h01},  // R5 gray
    '{2'd1, 1'b1, 6'b01_10_11, 8'h02},  // R6
    '{2'd1, 1'b1, 6'b11_00_10, 8'hF3},  // R6
    '{2'd1, 1'b0, 6'b00_01_00, 8'h03},  // R6 gray
    '{2'd2, 1'b1, 6'b11_11_11, 8'h0A},  // R7
    '{2'd2, 1'b1, 6'b00_00_00, 8'h0A},  // R7 bank no effect
    '{2'd2, 1'b0, 6'b10_10_10, 8'hF5},  // R7 gray
    '{2'd3, 1'b1, 6'b00_00_00, 8'hB6},  // R8
    '{2'd3, 1'b1, 6'b11_11_11, 8'hB6},  // R8
    '{2'd3, 1'b1, 6'b01_10_10, 8'h5D},  // R8
    '{2'd3, 1'b1, 6'b10_01_01, 8'hFF},  // R8
    '{2'd3, 1'b0, 6'b11_11_11, 8'hC3},  // R9
    '{2'd3, 1'b0, 6'b00_00_00, 8'h7E},  // R9
    '{2'd0, 1'b1, 6'b00_00_00, 8'h00}   // R5
  };

  initial begin
    logic [11:0] prev;
    for (int c = 0; c < 3; c++) for (int k = 0; k < 16; k++) pal[c][k] = 4'(k);
    #5;
    // R1: outputs zero during reset
    check("R1", {r_o, g_o, b_o}, 12'h000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {r_o, g_o, b_o}, 12'h000);
    // R1/R3: ramp readback
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 16; k++) begin
        chan = 2'(c); addr = 4'(k); #1;
        check("R1", {8'd0, rdata}, {8'd0, 4'(k)});
      end
    // R2: same-cycle read is old, next cycle new
    we = 1'b1; chan = 2'd1; addr = 4'd6; wdata = 4'hA; #1;
    check("R2", {8'd0, rdata}, 12'h006);
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    pal[1][6] = 4'hA;
    check("R2", {8'd0, rdata}, 12'h00A);
    // R4: dead channel
    we = 1'b1; chan = 2'd3; addr = 4'd2; wdata = 4'h9; #1;
    check("R4", {8'd0, rdata}, 12'h000);
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chan = 2'(c); addr = 4'd2; #1;
      check("R4", {8'd0, rdata}, 12'h002);
    end
    // program distinct palettes
    for (int k = 0; k < 16; k++) begin
      host_write(2'd0, 4'(k), 4'(15 - k));
      host_write(2'd1, 4'(k), 4'((k + 5) & 15));
      host_write(2'd2, 4'(k), 4'((k * 3) & 15));
    end
    // R3: readback of programmed values
    for (int c = 0; c < 3; c++) begin
      chan = 2'(c); addr = 4'd9; #1;
      check("R3", {8'd0, rdata}, {8'd0, pal[c][9]});
    end
    // vector walk; R10 latency checked before the edge
    @(negedge clk);
    prev = {r_o, g_o, b_o};
    for (int i = 0; i < NV; i++) begin
      depth = VECS[i].d; color = VECS[i].col; bank = VECS[i].bk; pixel = VECS[i].px;
      #1;
      check("R10", {r_o, g_o, b_o}, prev);
      @(posedge clk); @(negedge clk);
      prev = model_out(VECS[i].d, VECS[i].col, VECS[i].bk, VECS[i].px);
      if (VECS[i].col == 1'b0)
        check("R9", {r_o, g_o, b_o}, prev);
      else if (VECS[i].d == 2'd0) check("R5", {r_o, g_o, b_o}, prev);
      else if (VECS[i].d == 2'd1) check("R6", {r_o, g_o, b_o}, prev);
      else if (VECS[i].d == 2'd2) check("R7", {r_o, g_o, b_o}, prev);
      else                        check("R8", {r_o, g_o, b_o}, prev);
    end
    // R8 explicit: pixel B6, banks 0 -> r idx 5, g idx 5, b idx 2
    depth = 2'd3; color = 1'b1; bank = 6'd0; pixel = 8'hB6;
    @(posedge clk); @(negedge clk);
    check("R8", {r_o, g_o, b_o}, {4'd10, 4'd10, 4'd6});
    // R7 explicit: bank change has no effect at 4 bpp
    depth = 2'd2; pixel = 8'h03; bank = 6'b111111;
    @(posedge clk); @(negedge clk);
    check("R7", {r_o, g_o, b_o}, {4'd12, 4'd8, 4'd9});
    // R1: reset again restores ramp and clears outputs
    rst_n = 1'b0; #1;
    check("R1", {r_o, g_o, b_o}, 12'h000);
    chan = 2'd0; addr = 4'd3; #1;
    check("R1", {8'd0, rdata}, 12'h003);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule